// File: doc/BRIEF.md
# Set-Associative Tag Directory with Deferred-Eligibility LRU Replacement

This block is the tag directory and replacement controller of one cache bank. Each request carries a word address, a write flag and a valid bit. The address is split into a word offset, a set index and a tag. All ways of the indexed set are compared at once, and the outcome is reported in the cycle after the request is sampled. Reads that miss choose a victim way and start a block fill of fixed length. Writes never allocate; every write is signalled on a write-through strobe.

Replacement follows least-recently-used order, with one restriction: a block that has just been filled cannot be chosen as a victim until some request has hit it. This keeps two request streams from evicting each other's blocks forever. Each set has at most one fill in flight. A read miss to a set that is refilling is rejected. A read miss to a set whose ways are all ineligible is also rejected. A rejected read is expected to be resubmitted, and it hits once its fill has ended.

Top module: `cache_tag_dir`

## Requirements
- R1: The word address is split as follows. Bits [OFF_W-1:0] are the word offset and are ignored by the lookup. The next SET_W bits are the set index. The remaining upper bits are the tag. Blocks at consecutive block addresses therefore fall in consecutive sets, modulo 2^SET_W.
- R2: A request sampled at a clock edge is answered in the cycle after that edge, with rsp_valid high for exactly that cycle. Out of reset, rsp_valid, wt_strobe, fill_start and fill_done are all low.
- R3: A read whose tag matches a valid way of its set returns rsp_code 0 (hit) with rsp_way set to that way. That way becomes most recently used and is marked as referenced.
- R4: A read miss with at least one eligible way returns rsp_code 1 (miss). fill_start goes high with fill_set and fill_way naming the set and the victim. The victim is the least recently used eligible way, and it becomes most recently used. After reset, way w has age w (WAYS-1 is the oldest), so an untouched set fills ways WAYS-1 down to 0.
- R5: A way is eligible if it is empty, or if it has been hit at least once since its last fill. A filled way that has not yet been hit is skipped, even when it is the oldest.
- R6: A read miss to a set with no eligible way returns rsp_code 2 (reject) and starts no fill.
- R7: A fill occupies its set for FILL_LEN cycles. For a miss sampled at edge k, read misses to that set sampled at edges k+1 to k+FILL_LEN are rejected, including the one sampled at the very edge where the fill completes. fill_done and fill_done_set pulse in the cycle after edge k+FILL_LEN.
- R8: A write that hits returns rsp_code 0 with rsp_way and raises wt_strobe. It counts as a reference in the same way as a read hit. This also holds while another way of the same set is filling.
- R9: A write that misses returns rsp_code 3 (write-around) and raises wt_strobe. It starts no fill and allocates nothing, even when its set is busy, so a later read of that address still misses.
- R10: A rejected read that is resubmitted after its fill has ended hits the newly filled way.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Word address {tag, set, offset} |
| rsp_valid | output | 1 | Outcome valid (one cycle after the request) |
| rsp_code | output | 2 | 0 hit, 1 miss with fill, 2 reject, 3 write-around |
| rsp_way | output | WAY_W | Hit way or victim way |
| wt_strobe | output | 1 | Write passed through to memory |
| fill_start | output | 1 | A block fill begins |
| fill_set | output | SET_W | Set of the fill that begins |
| fill_way | output | WAY_W | Way being filled |
| fill_done | output | 1 | A fill has completed |
| fill_done_set | output | SET_W | Set whose fill has completed |

## Verification
Two functions can fall in the same cycle. The first is a fill completing. The second is a read to the same set that still misses, because the filled way is not yet valid. The bench provokes this case for every set and every way: after each miss it resubmits the same read on every following cycle. On the cycle where fill_done first appears, the response must still be a reject, and the next read must hit the victim way. A second overlap is a write hit to one way while another way of the same set is filling. That write must be reported as a hit and must count as a reference.

// File: rtl/ctd_pkg.sv
package ctd_pkg;
  typedef enum logic [1:0] {
    RSP_HIT      = 2'd0,
    RSP_MISS     = 2'd1,
    RSP_REJECT   = 2'd2,
    RSP_WRAROUND = 2'd3
  } rsp_code_e;
endpackage

// File: rtl/ctd_way_match.sv
module ctd_way_match #(
  parameter int WAYS  = 4,
  parameter int TAG_W = 6,
  localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
  input  logic [WAYS-1:0][TAG_W-1:0] tags_i,
  input  logic [WAYS-1:0]            valid_i,
  input  logic [TAG_W-1:0]           tag_i,
  output logic [WAYS-1:0]            match_o,
  output logic [WAY_W-1:0]           way_o
);
  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    assign match_o[w] = valid_i[w] && (tags_i[w] == tag_i);
  end

  always_comb begin
    way_o = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (match_o[w]) way_o = WAY_W'(w);
    end
  end
endmodule

// File: rtl/ctd_victim.sv
module ctd_victim #(
  parameter int WAYS = 4,
  localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1,
  localparam int AGE_W = WAY_W
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [WAYS-1:0]            elig_i,
  input  logic [WAYS-1:0][AGE_W-1:0] ages_i,
  output logic                       any_o,
  output logic [WAY_W-1:0]           way_o
);
  logic [AGE_W-1:0] best_age;

  always_comb begin
    any_o    = 1'b0;
    way_o    = '0;
    best_age = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (elig_i[w] && (!any_o || ages_i[w] > best_age)) begin
        any_o    = 1'b1;
        way_o    = WAY_W'(w);
        best_age = ages_i[w];
      end
    end
  end

  // R5: the chosen victim is always an eligible way
  a_r5_victim_eligible: assert property (@(posedge clk) disable iff (!rst_n)
    any_o |-> elig_i[way_o]);

  for (genvar w = 0; w < WAYS; w++) begin : g_chk
    // R4: no eligible way is older than the chosen victim
    a_r4_victim_oldest: assert property (@(posedge clk) disable iff (!rst_n)
      (any_o && elig_i[w]) |-> (ages_i[w] <= ages_i[way_o]));
  end
endmodule

// File: rtl/ctd_fill_timer.sv
module ctd_fill_timer #(
  parameter int FILL_LEN = 4,
  localparam int CNT_W = $clog2(FILL_LEN + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  output logic busy_o,
  output logic finish_o
);
  logic             busy_q, busy_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  assign busy_o   = busy_q;
  assign finish_o = busy_q && (cnt_q == '0);

  always_comb begin
    busy_d = busy_q;
    cnt_d  = cnt_q;
    if (start_i) begin
      busy_d = 1'b1;
      cnt_d  = CNT_W'(FILL_LEN - 1);
    end else if (finish_o) begin
      busy_d = 1'b0;
    end else if (busy_q) begin
      cnt_d  = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      busy_q <= busy_d;
      cnt_q  <= cnt_d;
    end
  end

  // R7: a set never starts a second fill while one is in flight
  a_r7_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |-> !busy_q);
endmodule

// File: rtl/cache_tag_dir.sv
module cache_tag_dir
  import ctd_pkg::*;
#(
  parameter int ADDR_W   = 10,
  parameter int OFF_W    = 2,
  parameter int SET_W    = 2,
  parameter int WAYS     = 4,
  parameter int FILL_LEN = 4,
  localparam int SETS  = 1 << SET_W,
  localparam int TAG_W = ADDR_W - SET_W - OFF_W,
  localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1,
  localparam int AGE_W = WAY_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              rsp_valid,
  output logic [1:0]        rsp_code,
  output logic [WAY_W-1:0]  rsp_way,
  output logic              wt_strobe,
  output logic              fill_start,
  output logic [SET_W-1:0]  fill_set,
  output logic [WAY_W-1:0]  fill_way,
  output logic              fill_done,
  output logic [SET_W-1:0]  fill_done_set
);
  // reset: asserted asynchronously, released on the clock
  logic [1:0] rsync_q;
  logic       rst_i_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= '0;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_i_n = rsync_q[1];

  // directory state
  logic [SETS-1:0][WAYS-1:0][TAG_W-1:0] tag_q, tag_d;
  logic [SETS-1:0][WAYS-1:0]            vld_q, vld_d;
  logic [SETS-1:0][WAYS-1:0]            refd_q, refd_d;
  logic [SETS-1:0][WAYS-1:0][AGE_W-1:0] age_q, age_d;
  logic [SETS-1:0][WAY_W-1:0]           fway_q, fway_d;

  // request decode
  logic [SET_W-1:0] req_set;
  logic [TAG_W-1:0] req_tag;
  assign req_set = req_addr[OFF_W +: SET_W];
  assign req_tag = req_addr[ADDR_W-1 -: TAG_W];

  logic [WAYS-1:0]  match;
  logic [WAY_W-1:0] hit_way;
  logic             hit;
  ctd_way_match #(.WAYS(WAYS), .TAG_W(TAG_W)) u_match (
    .tags_i (tag_q[req_set]),
    .valid_i(vld_q[req_set]),
    .tag_i  (req_tag),
    .match_o(match),
    .way_o  (hit_way)
  );
  assign hit = |match;

  logic [WAYS-1:0]  elig;
  logic             any_elig;
  logic [WAY_W-1:0] vict_way;
  assign elig = ~vld_q[req_set] | refd_q[req_set];
  ctd_victim #(.WAYS(WAYS)) u_victim (
    .clk   (clk),
    .rst_n (rst_i_n),
    .elig_i(elig),
    .ages_i(age_q[req_set]),
    .any_o (any_elig),
    .way_o (vict_way)
  );

  // per-set fill timers
  logic [SETS-1:0] start_vec, busy, finish;
  for (genvar s = 0; s < SETS; s++) begin : g_set
    ctd_fill_timer #(.FILL_LEN(FILL_LEN)) u_timer (
      .clk     (clk),
      .rst_n   (rst_i_n),
      .start_i (start_vec[s]),
      .busy_o  (busy[s]),
      .finish_o(finish[s])
    );
  end

  // outcome
  rsp_code_e        code;
  logic             touch, do_fill;
  logic [WAY_W-1:0] upd_way;
  logic [SET_W-1:0] fin_set;

  always_comb begin
    code    = RSP_HIT;
    touch   = 1'b0;
    do_fill = 1'b0;
    if (req_write) begin
      code  = hit ? RSP_HIT : RSP_WRAROUND;
      touch = req_valid && hit;
    end else if (hit) begin
      touch = req_valid;
    end else if (busy[req_set] || !any_elig) begin
      code  = RSP_REJECT;
    end else begin
      code    = RSP_MISS;
      do_fill = req_valid;
    end
    upd_way   = do_fill ? vict_way : hit_way;
    start_vec = '0;
    start_vec[req_set] = do_fill;
    fin_set = '0;
    for (int s = 0; s < SETS; s++) begin
      if (finish[s]) fin_set = SET_W'(s);
    end
  end

  // directory next state
  always_comb begin
    tag_d  = tag_q;
    vld_d  = vld_q;
    refd_d = refd_q;
    age_d  = age_q;
    fway_d = fway_q;
    for (int s = 0; s < SETS; s++) begin
      if (finish[s]) vld_d[s][fway_q[s]] = 1'b1;
    end
    if (touch || do_fill) begin
      for (int w = 0; w < WAYS; w++) begin
        if (WAY_W'(w) == upd_way)
          age_d[req_set][w] = '0;
        else if (age_q[req_set][w] < age_q[req_set][upd_way])
          age_d[req_set][w] = age_q[req_set][w] + 1'b1;
      end
    end
    if (touch) refd_d[req_set][hit_way] = 1'b1;
    if (do_fill) begin
      tag_d[req_set][vict_way]  = req_tag;
      vld_d[req_set][vict_way]  = 1'b0;
      refd_d[req_set][vict_way] = 1'b0;
      fway_d[req_set]           = vict_way;
    end
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      tag_q  <= '0;
      vld_q  <= '0;
      refd_q <= '0;
      fway_q <= '0;
      for (int s = 0; s < SETS; s++)
        for (int w = 0; w < WAYS; w++)
          age_q[s][w] <= AGE_W'(w);
    end else begin
      tag_q  <= tag_d;
      vld_q  <= vld_d;
      refd_q <= refd_d;
      age_q  <= age_d;
      fway_q <= fway_d;
    end
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      rsp_valid     <= 1'b0;
      rsp_code      <= '0;
      rsp_way       <= '0;
      wt_strobe     <= 1'b0;
      fill_start    <= 1'b0;
      fill_set      <= '0;
      fill_way      <= '0;
      fill_done     <= 1'b0;
      fill_done_set <= '0;
    end else begin
      rsp_valid     <= req_valid;
      rsp_code      <= code;
      rsp_way       <= upd_way;
      wt_strobe     <= req_valid && req_write;
      fill_start    <= do_fill;
      fill_set      <= req_set;
      fill_way      <= vict_way;
      fill_done     <= |finish;
      fill_done_set <= fin_set;
    end
  end

  function automatic int unsigned age_sum(input logic [WAYS-1:0][AGE_W-1:0] a);
    int unsigned acc = 0;
    for (int w = 0; w < WAYS; w++) acc += int'(a[w]);
    return acc;
  endfunction

  // R3: a tag is present in at most one way of a set
  a_r3_match_unique: assert property (@(posedge clk) disable iff (!rst_i_n)
    $onehot0(match));
  // R7: fills in different sets never end in the same cycle
  a_r7_one_finish: assert property (@(posedge clk) disable iff (!rst_i_n)
    $onehot0(finish));
  // R9: a write never launches a fill
  a_r9_write_no_fill: assert property (@(posedge clk) disable iff (!rst_i_n)
    (rsp_valid && wt_strobe) |-> !fill_start);
  // R6: a reject never launches a fill
  a_r6_reject_no_fill: assert property (@(posedge clk) disable iff (!rst_i_n)
    (rsp_valid && rsp_code == 2'd2) |-> !fill_start);
  for (genvar s = 0; s < SETS; s++) begin : g_age_chk
    // R4: the ages of a set stay a permutation of 0..WAYS-1
    a_r4_age_perm: assert property (@(posedge clk) disable iff (!rst_i_n)
      age_sum(age_q[s]) == WAYS * (WAYS - 1) / 2);
  end
endmodule

// File: tb/cache_tag_dir_bench.sv
module cache_tag_dir_bench;
  localparam int CLK_PERIOD = 10;
  localparam int L = 4;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       req_valid, req_write;
  logic [9:0] req_addr;
  logic       rsp_valid, wt_strobe, fill_start, fill_done;
  logic [1:0] rsp_code, rsp_way, fill_set, fill_way, fill_done_set;

  int n_chk  = 0;
  int n_fail = 0;
  bit finished = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  cache_tag_dir #(.ADDR_W(10), .OFF_W(2), .SET_W(2), .WAYS(4), .FILL_LEN(L)) u_cache_tag_dir (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .rsp_valid(rsp_valid), .rsp_code(rsp_code),
    .rsp_way(rsp_way), .wt_strobe(wt_strobe), .fill_start(fill_start),
    .fill_set(fill_set), .fill_way(fill_way), .fill_done(fill_done),
    .fill_done_set(fill_done_set)
  );

  function automatic logic [9:0] mk(input int tag, input int set, input int off);
    return 10'((tag << 4) | (set << 2) | off);
  endfunction

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic cyc(input logic v, input logic w, input logic [9:0] a);
    @(negedge clk);
    req_valid = v;
    req_write = w;
    req_addr  = a;
    @(posedge clk);
    #1;
    req_valid = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      cyc(1'b0, 1'b0, '0);
      check("R2 no response when idle", int'(rsp_valid), 0);
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    req_valid = 1'b0;
    req_write = 1'b0;
    req_addr  = '0;
    rst_n     = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    check("R2 reset rsp_valid", int'(rsp_valid), 0);
    check("R2 reset fill_start", int'(fill_start), 0);
    check("R2 reset fill_done", int'(fill_done), 0);
    check("R2 reset wt_strobe", int'(wt_strobe), 0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(posedge clk);

    // sweep: every set, every way; reject on each fill cycle, hit afterwards
    for (int s = 0; s < 4; s++) begin
      for (int t = 0; t < 4; t++) begin
        cyc(1'b1, 1'b0, mk(t, s, 0));
        check("R4 miss code", int'(rsp_code), 1);
        check("R2 rsp_valid", int'(rsp_valid), 1);
        check("R4 fill_start", int'(fill_start), 1);
        check("R1 fill_set", int'(fill_set), s);
        check("R4 fill_way lru order", int'(fill_way), 3 - t);
        for (int i = 1; i <= L; i++) begin
          cyc(1'b1, 1'b0, mk(t, s, i % 4));
          check("R7 reject while filling", int'(rsp_code), 2);
          check("R7 no second fill", int'(fill_start), 0);
          check("R7 fill_done timing", int'(fill_done), (i == L) ? 1 : 0);
          if (i == L) check("R7 fill_done_set", int'(fill_done_set), s);
        end
        cyc(1'b1, 1'b0, mk(t, s, 3));
        check("R10 resubmitted read hits", int'(rsp_code), 0);
        check("R3 hit way", int'(rsp_way), 3 - t);
        check("R7 fill_done one pulse", int'(fill_done), 0);
      end
    end
    idle(1);

    // set 0: an unreferenced fresh block is skipped although oldest (R5)
    cyc(1'b1, 1'b0, mk(8, 0, 0));
    check("R4 victim oldest", int'(fill_way), 3);
    idle(L);
    cyc(1'b1, 1'b0, mk(1, 0, 0)); check("R3 hit tag1", int'(rsp_way), 2);
    cyc(1'b1, 1'b0, mk(2, 0, 0)); check("R3 hit tag2", int'(rsp_way), 1);
    cyc(1'b1, 1'b0, mk(3, 0, 0)); check("R3 hit tag3", int'(rsp_way), 0);
    cyc(1'b1, 1'b0, mk(9, 0, 0));
    check("R5 miss code", int'(rsp_code), 1);
    check("R5 fresh way skipped", int'(fill_way), 2);
    cyc(1'b1, 1'b0, mk(0, 0, 0));
    check("R7 evicted tag rejected while busy", int'(rsp_code), 2);
    cyc(1'b1, 1'b1, mk(11, 0, 0));
    check("R9 write miss code when busy", int'(rsp_code), 3);
    check("R9 write strobe", int'(wt_strobe), 1);
    check("R9 write no fill", int'(fill_start), 0);
    idle(L);
    cyc(1'b1, 1'b0, mk(11, 0, 0));
    check("R9 no allocation on write", int'(rsp_code), 1);
    check("R5 victim among referenced", int'(fill_way), 1);
    idle(L);

    // set 1: fill all ways with no hits, then nothing is eligible (R6)
    for (int t = 0; t < 4; t++) begin
      cyc(1'b1, 1'b0, mk(20 + t, 1, 0));
      check("R4 miss code", int'(rsp_code), 1);
      check("R5 victim skips fresh ways", int'(fill_way), 3 - t);
      idle(L);
    end
    cyc(1'b1, 1'b0, mk(24, 1, 0));
    check("R6 no eligible way rejects", int'(rsp_code), 2);
    check("R6 no fill", int'(fill_start), 0);
    cyc(1'b1, 1'b1, mk(20, 1, 1));
    check("R8 write hit code", int'(rsp_code), 0);
    check("R8 write hit way", int'(rsp_way), 3);
    check("R8 write strobe", int'(wt_strobe), 1);
    cyc(1'b1, 1'b0, mk(25, 1, 0));
    check("R8 write hit makes way eligible", int'(rsp_code), 1);
    check("R8 victim is written way", int'(fill_way), 3);
    idle(L);

    // set 2: write hit, write miss, and a write hit during a fill
    cyc(1'b1, 1'b1, mk(1, 2, 0));
    check("R8 write hit code", int'(rsp_code), 0);
    check("R8 write hit way", int'(rsp_way), 2);
    cyc(1'b1, 1'b1, mk(30, 2, 0));
    check("R9 write miss code", int'(rsp_code), 3);
    check("R9 write strobe", int'(wt_strobe), 1);
    check("R9 write miss no fill", int'(fill_start), 0);
    cyc(1'b1, 1'b0, mk(30, 2, 0));
    check("R9 read after write misses", int'(rsp_code), 1);
    check("R4 victim oldest", int'(fill_way), 3);
    cyc(1'b1, 1'b1, mk(2, 2, 0));
    check("R8 write hit during fill", int'(rsp_code), 0);
    check("R8 write hit way during fill", int'(rsp_way), 1);
    idle(L);
    cyc(1'b1, 1'b0, mk(30, 2, 2));
    check("R10 read hits after fill", int'(rsp_code), 0);
    check("R10 filled way", int'(rsp_way), 3);
    cyc(1'b1, 1'b0, mk(5, 3, 0) + 10'd16);
    check("R1 unknown tag in set 3 misses", int'(rsp_code), 1);
    check("R1 set field", int'(fill_set), 3);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule